// File: doc/BRIEF.md
# Level Sense Detect and Latch

This block watches a vector of up to 32 input pins and flags when any of them sits at a level that software has asked it to watch for. Each pin has its own two-bit sense field that selects no sensing, sensing a high level, or sensing a low level. Every pin passes through a synchronizer. After that, it is compared with its sense setting. The OR of all matches drives one shared detect line.

The detect line does not say which pin caused it. A sticky latch with one bit per pin records every pin that has matched. Software reads the latch to find the source pins, then writes the same value back to clear those bits.

A single port event flag is raised when detect goes from low to high. Software clears it with a write to its register. The interrupt output is that flag gated by an enable bit. All state is reached through a simple synchronous write bus with a combinational read path.

Top module: `lsd_level_sense`

## Requirements
- R1: Each pin n has a configuration register at address n, with the sense field in bits [1:0]. The encoding is 00 = off, 01 = sense high, 10 = sense low, and 11 = off. The field reads back as written, and the other read bits are zero.
- R2: `detect_o` is high exactly when at least one pin with sense on sits at its configured level. Pin inputs pass through a two-flop synchronizer, so detect follows a pin change after two clock edges.
- R3: A latch bit, once set, stays set until a clear write at address 32 carries a one in that bit position.
- R4: On the clock edge after a pin's match becomes visible on `detect_o`, that pin's latch bit is set. The latch reads at address 32, with bit n for pin n.
- R5: A write to address 32 clears each latch bit whose write data bit is one. A bit whose pin still matches in the same cycle stays set.
- R6: The port event flag reads as bit 0 at address 33. It is set one cycle after `detect_o` rises. While detect stays high, the flag is not raised again until detect has fallen.
- R7: Any write to address 33 clears the port event flag, unless detect rises in that same cycle.
- R8: `irq_o` is high exactly when the port event flag is set and the interrupt enable, bit 0 at address 34, is one.
- R9: When a pin's sense field is set to off, that pin no longer drives `detect_o` or sets its latch bit, whatever its level.
- R10: After reset, all sense fields are off, and the latch, the event flag and the interrupt enable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NPINS | Pin levels, asynchronous to the clock |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Register address for both read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| detect_o | output | 1 | Any enabled pin is at its sense level |
| irq_o | output | 1 | Port event flag gated by the interrupt enable |

## Verification
Two pairs of actions can collide in one clock cycle:
- A latch clear and a still-matching pin.
- An event clear and a held detect.

The bench provokes both with directed sequences. It holds a pin at its sense level, writes back the latch value it has just read, and expects the bit to survive. It then clears the event while detect stays high and expects the flag to stay low. A bench model of sense matching, latch accumulation and event rise judges every read. The same model also covers constrained random runs that interleave configuration writes, pin changes and clears.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   typedef enum logic [1:0] {
      SENSE_OFF  = 2'b00,
      SENSE_HIGH = 2'b01,
      SENSE_LOW  = 2'b10,
      SENSE_RSVD = 2'b11
   } sense_e;

   localparam int unsigned REG_LATCH = 32;
   localparam int unsigned REG_EVENT = 33;
   localparam int unsigned REG_IEN   = 34;

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lsd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[0] <= '0;
      else         chain_q[0] <= d_i;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[k] <= '0;
         else         chain_q[k] <= chain_q[k-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsd_cfg.sv
module lsd_cfg #(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   wr_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [1:0]             data_i,
   output logic [NPINS-1:0][1:0]  cfg_o
);
   import lsd_pkg::*;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cfg_o[i] <= SENSE_OFF;
         else if (wr_i && (addr_i == ADDR_W'(i)))
            cfg_o[i] <= data_i;
      end
   end
endmodule

// File: rtl/lsd_match.sv
module lsd_match #(
   parameter int unsigned NPINS = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NPINS-1:0][1:0] cfg_i,
   input  logic [NPINS-1:0]      pins_i,
   output logic [NPINS-1:0]      hit_o
);
   import lsd_pkg::*;

   logic [NPINS-1:0] off_mask;

   for (genvar i = 0; i < NPINS; i++) begin : g_cmp
      always_comb begin
         case (cfg_i[i])
            SENSE_HIGH: hit_o[i] = pins_i[i];
            SENSE_LOW:  hit_o[i] = ~pins_i[i];
            default:    hit_o[i] = 1'b0;
         endcase
      end
      assign off_mask[i] = (cfg_i[i] == SENSE_OFF) || (cfg_i[i] == SENSE_RSVD);
   end

   // R9: a pin whose sense is off never contributes a match
   a_r9_off_never_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hit_o & off_mask) == '0));
endmodule

// File: rtl/lsd_level_sense.sv
module lsd_level_sense #(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPINS-1:0]  pins_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              detect_o,
   output logic              irq_o
);
   import lsd_pkg::*;

   localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("lsd_level_sense: NPINS must lie in 1..32");
   end
   if (DATA_W < NPINS) begin : g_bad_data_w
      $error("lsd_level_sense: DATA_W must cover NPINS");
   end
   if ((1 << ADDR_W) <= REG_IEN) begin : g_bad_addr_w
      $error("lsd_level_sense: ADDR_W too small for register map");
   end

   logic [NPINS-1:0]      pins_s;
   logic [NPINS-1:0]      hit;
   logic [NPINS-1:0][1:0] cfg;
   logic [NPINS-1:0]      latch_q;
   logic                  det_q;
   logic                  event_q;
   logic                  ien_q;
   logic                  cfg_wr, clr_latch, ev_wr, ien_wr, ev_rise;

   assign cfg_wr    = bus_wr_i && (bus_addr_i < ADDR_W'(NPINS));
   assign clr_latch = bus_wr_i && (bus_addr_i == ADDR_W'(REG_LATCH));
   assign ev_wr     = bus_wr_i && (bus_addr_i == ADDR_W'(REG_EVENT));
   assign ien_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(REG_IEN));

   lsd_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_i),
      .q_o    (pins_s)
   );

   lsd_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cfg_wr),
      .addr_i (bus_addr_i),
      .data_i (bus_wdata_i[1:0]),
      .cfg_o  (cfg)
   );

   lsd_match #(.NPINS(NPINS)) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg),
      .pins_i (pins_s),
      .hit_o  (hit)
   );

   assign detect_o = |hit;
   assign ev_rise  = detect_o & ~det_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         latch_q <= '0;
         det_q   <= 1'b0;
         event_q <= 1'b0;
         ien_q   <= 1'b0;
      end else begin
         latch_q <= (latch_q & ~(clr_latch ? bus_wdata_i[NPINS-1:0] : '0)) | hit;
         det_q   <= detect_o;
         if (ev_rise)    event_q <= 1'b1;
         else if (ev_wr) event_q <= 1'b0;
         if (ien_wr)     ien_q   <= bus_wdata_i[0];
      end
   end

   assign irq_o = event_q & ien_q;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i < ADDR_W'(NPINS)) begin
         bus_rdata_o[1:0] = cfg[bus_addr_i[IDX_W-1:0]];
      end else if (bus_addr_i == ADDR_W'(REG_LATCH)) begin
         bus_rdata_o[NPINS-1:0] = latch_q;
      end else if (bus_addr_i == ADDR_W'(REG_EVENT)) begin
         bus_rdata_o[0] = event_q;
      end else if (bus_addr_i == ADDR_W'(REG_IEN)) begin
         bus_rdata_o[0] = ien_q;
      end
   end

   // R3: without a clear write no latch bit drops
   a_r3_latch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_latch |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

   // R5: a matching pin keeps its latch bit even across a clear
   a_r5_match_survives_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|hit) |=> ((latch_q & $past(hit)) == $past(hit)));

   // R6: rising detect raises the event flag
   a_r6_event_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(detect_o) |=> event_q);

   // R7: clearing write without a rise empties the flag
   a_r7_event_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_wr && !ev_rise) |=> !event_q);

   // R8: interrupt never fires while disabled
   a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ien_q |-> !irq_o);
endmodule

// File: tb/lsd_level_sense_bench.sv
module lsd_level_sense_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic          wr = 1'b0;
   logic [5:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          detect, irq;

   int checks = 0;
   int errors = 0;

   logic [1:0]    m_cfg [NP];
   logic [NP-1:0] m_pins = '0;
   logic [NP-1:0] m_latch = '0;
   logic          m_event = 1'b0;
   logic          m_ien = 1'b0;
   logic          m_pdet = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsd_level_sense u_lsd_level_sense (
      .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .detect_o(detect), .irq_o(irq)
   );

   function automatic logic [NP-1:0] model_hit();
      logic [NP-1:0] h = '0;
      for (int i = 0; i < NP; i++) begin
         if (m_cfg[i] == 2'b01) h[i] = m_pins[i];
         else if (m_cfg[i] == 2'b10) h[i] = ~m_pins[i];
      end
      return h;
   endfunction

   task automatic model_step();
      logic [NP-1:0] h = model_hit();
      m_latch = m_latch | h;
      if ((|h) && !m_pdet) m_event = 1'b1;
      m_pdet = |h;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic cfg_write(int pin, logic [1:0] v);
      bus_write(6'(pin), {30'b0, v});
      m_cfg[pin] = v;
      model_step();
   endtask

   task automatic set_pins(logic [NP-1:0] v);
      @(negedge clk);
      pins = v;
      repeat (3) @(negedge clk);
      m_pins = v;
      model_step();
   endtask

   task automatic latch_clear(logic [NP-1:0] mask);
      bus_write(6'd32, mask);
      m_latch = (m_latch & ~mask) | model_hit();
   endtask

   task automatic event_clear();
      bus_write(6'd33, 32'h1);
      m_event = 1'b0;
   endtask

   task automatic check_all(string tag);
      logic [31:0] d;
      @(negedge clk);
      check({tag, " R2 detect"}, {31'b0, detect}, {31'b0, |model_hit()});
      bus_read(6'd32, d);
      check({tag, " R4 latch"}, d, m_latch);
      bus_read(6'd33, d);
      check({tag, " R6 event"}, d, {31'b0, m_event});
      check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, m_event & m_ien});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      for (int i = 0; i < NP; i++) m_cfg[i] = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      bus_read(6'd7, d);  check("R10 cfg reset", d, 32'h0);
      bus_read(6'd32, d); check("R10 latch reset", d, 32'h0);
      bus_read(6'd33, d); check("R10 event reset", d, 32'h0);
      bus_read(6'd34, d); check("R10 ien reset", d, 32'h0);
      check("R10 detect reset", {31'b0, detect}, 32'h0);

      // R1 encoding readback
      cfg_write(3, 2'b11);
      bus_read(6'd3, d); check("R1 cfg readback", d, 32'h3);
      check("R1 reserved code is off", {31'b0, detect}, 32'h0);
      cfg_write(3, 2'b10);
      bus_read(6'd3, d); check("R1 cfg readback low", d, 32'h2);
      check_all("R1 low sense on zero pin");
      bus_write(6'd34, 32'h1); m_ien = 1'b1;
      check_all("R8 irq enabled");
      latch_clear(32'hFFFF_FFFF);
      event_clear();
      cfg_write(3, 2'b00);
      latch_clear(32'hFFFF_FFFF);
      check_all("R9 after disable");

      // R5: clear while pin matches keeps bit
      cfg_write(5, 2'b01);
      set_pins(32'h20);
      check_all("R5 setup");
      bus_read(6'd32, d);
      latch_clear(d[NP-1:0]);
      check_all("R5 clear while matching");
      bus_read(6'd32, d); check("R5 bit survives", d, 32'h20);

      // R7/R6: event cleared while detect held does not re-raise
      event_clear();
      repeat (5) @(negedge clk);
      check_all("R6 no retrigger while held");
      bus_read(6'd33, d); check("R7 event cleared", d, 32'h0);
      set_pins(32'h0);
      set_pins(32'h20);
      check_all("R6 retrigger after fall");

      // R9: disabling removes pin though still high
      cfg_write(5, 2'b00);
      latch_clear(32'hFFFF_FFFF);
      check_all("R9 disabled pin");
      bus_read(6'd32, d); check("R9 latch stays clear", d, 32'h0);

      // R8 enable off masks irq
      set_pins(32'h0);
      cfg_write(9, 2'b10);
      bus_write(6'd34, 32'h0); m_ien = 1'b0;
      check_all("R8 irq masked");
      bus_write(6'd34, 32'h1); m_ien = 1'b1;
      check_all("R8 irq unmasked");

      // Random mixing, R2 R3 R4
      for (int it = 0; it < 60; it++) begin
         for (int k = 0; k < 3; k++) cfg_write($urandom % NP, 2'($urandom % 4));
         set_pins($urandom);
         check_all("R3 random");
         if ($urandom % 2) begin
            bus_read(6'd32, d);
            latch_clear(d[NP-1:0] & $urandom);
            check_all("R5 random clear");
         end
         if ($urandom % 3 == 0) begin
            event_clear();
            check_all("R7 random event clear");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule